// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits beside a memory controller's ECC datapath and keeps a record of the errors that datapath reports. It receives one strobe per correctable error and one strobe per uncorrectable error, each with the failing address. It counts both kinds in saturating counters and keeps one address for each kind. For uncorrectable errors it keeps the first address since the last clear. For correctable errors it keeps the most recent address. A level-high interrupt stays asserted while an enabled error class has a nonzero count.

Software reaches the block through a simple 32-bit register port with byte offsets. A read returns data combinationally from the addressed register, and a write takes effect at the clock edge. All writes except those to the key register are gated by a protection key: writing the unlock value opens the other registers, and writing any other value closes them. The configuration register holds the ECC-enable and DRAM-type bits. The interrupt control word packs the two enables, both counters and a clear control. Software clears the counters by writing the clear bit to 1 and then back to 0.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the block is locked, every register reads 0 and `irq` is low.
- R2: A write of 0xFC600309 to offset 0x00 unlocks the block, and a write of any other value there locks it. Key writes are accepted in either state. A read of offset 0x00 returns 1 when unlocked and 0 when locked.
- R3: While the block is locked, writes to the configuration and interrupt control registers are dropped. Reads of all registers still work, and error counting continues.
- R4: The configuration register sits at offset 0x04. Bit 7 enables ECC event logging, and bit 4 selects the DRAM type (1 = DDR4, 0 = DDR3). All other bits read 0.
- R5: Bits 23:16 of the interrupt control word at offset 0x50 count accepted correctable events. The count rises by one per event and holds at 255.
- R6: Bits 15:12 of the same word count accepted uncorrectable events. The count rises by one per event and holds at 15.
- R7: Offset 0x58 holds the address of the first uncorrectable event accepted since reset or the last clear. Later uncorrectable events do not change it.
- R8: Offset 0x5C holds the address of the most recent accepted correctable event.
- R9: Error events are ignored while ECC mode (bit 7 of offset 0x04) is 0.
- R10: Bit 0 at offset 0x50 enables the correctable interrupt and bit 1 enables the uncorrectable interrupt. `irq` is high exactly while an enabled class has a nonzero count. `irq` does not depend on events alone.
- R11: Bit 31 at offset 0x50 reads back as written. While it is 1, both counts are zero, events are ignored and the first-address capture is re-armed. The address registers keep their values until a new event is captured.
- R12: Writes to offsets 0x58 and 0x5C and to the count fields have no effect, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ce_evt | input | 1 | Correctable error strobe, one cycle per event |
| ce_evt_addr | input | ERR_AW | Address of the correctable error |
| ue_evt | input | 1 | Uncorrectable error strobe, one cycle per event |
| ue_evt_addr | input | ERR_AW | Address of the uncorrectable error |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest states to reach from the ports are the saturation points of the counters, in particular the correctable count at 255. Each step toward that point needs a separate event strobe, and ECC mode must first be enabled through an unlocked write. The stimulus therefore unlocks the block, enables ECC and drives 260 correctable pulses and 20 uncorrectable pulses so that both counters run past their limits. It then holds the clear bit while events keep arriving, to show that the events are ignored and that the first-address capture is re-armed. A behavioural model in the bench tracks every register and `irq` on each clock and compares them.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  localparam int OFF_KEY     = 'h00;
  localparam int OFF_CFG     = 'h04;
  localparam int OFF_IRQCTL  = 'h50;
  localparam int OFF_UE_ADDR = 'h58;
  localparam int OFF_CE_ADDR = 'h5C;

  localparam int CFG_ECC_BIT  = 7;
  localparam int CFG_DDR4_BIT = 4;
  localparam int CLR_BIT      = 31;
  localparam int CE_CNT_LSB   = 16;
  localparam int UE_CNT_LSB   = 12;
  localparam int CE_CNT_W     = 8;
  localparam int UE_CNT_W     = 4;

  typedef struct packed {
    logic ecc_on;
    logic ddr4;
  } cfg_t;

  typedef struct packed {
    logic clr;
    logic ue_en;
    logic ce_en;
  } irqctl_t;

  function automatic logic [31:0] pack_cfg(cfg_t c);
    logic [31:0] w;
    w = '0;
    w[CFG_ECC_BIT]  = c.ecc_on;
    w[CFG_DDR4_BIT] = c.ddr4;
    return w;
  endfunction

  function automatic logic [31:0] pack_irqctl(irqctl_t c, logic [CE_CNT_W-1:0] ce,
                                              logic [UE_CNT_W-1:0] ue);
    logic [31:0] w;
    w = '0;
    w[CLR_BIT] = c.clr;
    w[CE_CNT_LSB +: CE_CNT_W] = ce;
    w[UE_CNT_LSB +: UE_CNT_W] = ue;
    w[1] = c.ue_en;
    w[0] = c.ce_en;
    return w;
  endfunction
endpackage

// File: rtl/ecc_key_guard.sv
module ecc_key_guard #(
  parameter logic [31:0] KEY = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  output logic        unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (key_data == KEY);
  end
endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] bump(logic [W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= bump(count);
  end
endmodule

// File: rtl/ecc_addr_capture.sv
module ecc_addr_capture #(
  parameter int W          = 32,
  parameter bit KEEP_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rearm,
  input  logic         hit,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] addr_q
);
  generate
    if (KEEP_FIRST) begin : g_first
      logic held;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          addr_q <= '0;
          held   <= 1'b0;
        end else if (rearm) begin
          held <= 1'b0;
        end else if (hit && !held) begin
          addr_q <= addr_in;
          held   <= 1'b1;
        end
      end
    end else begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              addr_q <= '0;
        else if (hit && !rearm)  addr_q <= addr_in;
      end
    end
  endgenerate
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ERR_AW = 32,
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ce_evt,
  input  logic [ERR_AW-1:0] ce_evt_addr,
  input  logic              ue_evt,
  input  logic [ERR_AW-1:0] ue_evt_addr,
  output logic              irq
);
  logic bus_wr, hit_key, hit_cfg, hit_ctl, hit_ue, hit_ce;
  logic key_wr, unlocked, wr_ok;
  cfg_t    cfg_q;
  irqctl_t ctl_q;
  logic clr_active, ce_accept, ue_accept, irq_ce_req, irq_ue_req;
  logic [CE_CNT_W-1:0] ce_cnt;
  logic [UE_CNT_W-1:0] ue_cnt;
  logic [ERR_AW-1:0]   ue_addr, ce_addr;

  assign bus_wr  = bus_en & bus_we;
  assign hit_key = (bus_addr == BUS_AW'(OFF_KEY));
  assign hit_cfg = (bus_addr == BUS_AW'(OFF_CFG));
  assign hit_ctl = (bus_addr == BUS_AW'(OFF_IRQCTL));
  assign hit_ue  = (bus_addr == BUS_AW'(OFF_UE_ADDR));
  assign hit_ce  = (bus_addr == BUS_AW'(OFF_CE_ADDR));
  assign key_wr  = bus_wr & hit_key;

  ecc_key_guard #(.KEY(UNLOCK_KEY)) u_guard (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(bus_wdata), .unlocked(unlocked)
  );

  assign wr_ok = bus_wr & unlocked & ~hit_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_ok && hit_cfg) begin
        cfg_q.ecc_on <= bus_wdata[CFG_ECC_BIT];
        cfg_q.ddr4   <= bus_wdata[CFG_DDR4_BIT];
      end
      if (wr_ok && hit_ctl) begin
        ctl_q.clr   <= bus_wdata[CLR_BIT];
        ctl_q.ue_en <= bus_wdata[1];
        ctl_q.ce_en <= bus_wdata[0];
      end
    end
  end

  assign clr_active = ctl_q.clr;
  assign ce_accept  = ce_evt & cfg_q.ecc_on & ~clr_active;
  assign ue_accept  = ue_evt & cfg_q.ecc_on & ~clr_active;

  ecc_sat_counter #(.W(CE_CNT_W)) u_ce_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_active), .inc(ce_accept), .count(ce_cnt)
  );
  ecc_sat_counter #(.W(UE_CNT_W)) u_ue_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_active), .inc(ue_accept), .count(ue_cnt)
  );

  ecc_addr_capture #(.W(ERR_AW), .KEEP_FIRST(1'b1)) u_ue_cap (
    .clk(clk), .rst_n(rst_n), .rearm(clr_active), .hit(ue_accept),
    .addr_in(ue_evt_addr), .addr_q(ue_addr)
  );
  ecc_addr_capture #(.W(ERR_AW), .KEEP_FIRST(1'b0)) u_ce_cap (
    .clk(clk), .rst_n(rst_n), .rearm(clr_active), .hit(ce_accept),
    .addr_in(ce_evt_addr), .addr_q(ce_addr)
  );

  assign irq_ce_req = ctl_q.ce_en & (|ce_cnt);
  assign irq_ue_req = ctl_q.ue_en & (|ue_cnt);
  assign irq        = irq_ce_req | irq_ue_req;

  always_comb begin
    bus_rdata = '0;
    if (hit_key)      bus_rdata = {31'b0, unlocked};
    else if (hit_cfg) bus_rdata = pack_cfg(cfg_q);
    else if (hit_ctl) bus_rdata = pack_irqctl(ctl_q, ce_cnt, ue_cnt);
    else if (hit_ue)  bus_rdata = 32'(ue_addr);
    else if (hit_ce)  bus_rdata = 32'(ce_addr);
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int ERR_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              locked_cfg_wr,
  input logic [1:0]        cfg_bits,
  input logic              ecc_on,
  input logic              clr_active,
  input logic              ce_accept,
  input logic              ue_accept,
  input logic [7:0]        ce_cnt,
  input logic [3:0]        ue_cnt,
  input logic [ERR_AW-1:0] ce_evt_addr,
  input logic [ERR_AW-1:0] ce_addr,
  input logic [ERR_AW-1:0] ue_addr,
  input logic              irq
);
  // R3
  locked_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_cfg_wr |=> $stable(cfg_bits));
  // R5
  ce_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_accept && ce_cnt != 8'hFF) |=> ce_cnt == $past(ce_cnt) + 8'd1);
  // R5
  ce_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_accept && ce_cnt == 8'hFF) |=> ce_cnt == 8'hFF);
  // R6
  ue_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_accept && ue_cnt == 4'hF) |=> ue_cnt == 4'hF);
  // R7
  ue_first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_cnt != 4'd0 && !clr_active) |=> $stable(ue_addr));
  // R8
  ce_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_accept |=> ce_addr == $past(ce_evt_addr));
  // R9
  ecc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_on && !clr_active) |=> ($stable(ce_cnt) && $stable(ue_cnt)));
  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |=> (ce_cnt == 8'd0 && ue_cnt == 4'd0));
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_cnt == 8'd0 && ue_cnt == 4'd0) |-> !irq);
endmodule

bind ecc_err_log ecc_err_log_chk #(.ERR_AW(ERR_AW)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .locked_cfg_wr(bus_wr & ~unlocked & hit_cfg),
  .cfg_bits({cfg_q.ecc_on, cfg_q.ddr4}),
  .ecc_on(cfg_q.ecc_on), .clr_active(clr_active),
  .ce_accept(ce_accept), .ue_accept(ue_accept),
  .ce_cnt(ce_cnt), .ue_cnt(ue_cnt),
  .ce_evt_addr(ce_evt_addr), .ce_addr(ce_addr), .ue_addr(ue_addr),
  .irq(irq)
);

// File: tb/test_ecc_err_log.sv
`timescale 1ns/1ps
module test_ecc_err_log;
  localparam logic [31:0] KEY = 32'hFC60_0309;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ce_evt = 1'b0, ue_evt = 1'b0;
  logic [31:0] ce_evt_addr = '0, ue_evt_addr = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ce_evt(ce_evt), .ce_evt_addr(ce_evt_addr),
    .ue_evt(ue_evt), .ue_evt_addr(ue_evt_addr), .irq(irq)
  );

  // behavioural reference state
  bit m_open, m_ecc, m_ddr4, m_clr, m_en_ce, m_en_ue, m_ue_seen;
  int m_ce_n, m_ue_n;
  logic [31:0] m_ue_a, m_ce_a;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_ecc = 0; m_ddr4 = 0; m_clr = 0; m_en_ce = 0; m_en_ue = 0;
      m_ue_seen = 0; m_ce_n = 0; m_ue_n = 0; m_ue_a = 0; m_ce_a = 0;
    end else begin
      bit live;
      live = m_ecc && !m_clr;
      if (m_clr) begin
        m_ce_n = 0; m_ue_n = 0; m_ue_seen = 0;
      end else begin
        if (live && ce_evt) begin
          if (m_ce_n < 255) m_ce_n++;
          m_ce_a = ce_evt_addr;
        end
        if (live && ue_evt) begin
          if (m_ue_n < 15) m_ue_n++;
          if (!m_ue_seen) begin m_ue_a = ue_evt_addr; m_ue_seen = 1; end
        end
      end
      if (bus_en && bus_we) begin
        if (bus_addr == 8'h00) m_open = (bus_wdata == KEY);
        else if (m_open && bus_addr == 8'h04) begin
          m_ecc = bus_wdata[7]; m_ddr4 = bus_wdata[4];
        end else if (m_open && bus_addr == 8'h50) begin
          m_clr = bus_wdata[31]; m_en_ue = bus_wdata[1]; m_en_ce = bus_wdata[0];
        end
      end
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_open ? 32'd1 : 32'd0;
      8'h04: return (m_ecc ? 32'h80 : 32'h0) | (m_ddr4 ? 32'h10 : 32'h0);
      8'h50: return (m_clr ? 32'h8000_0000 : 32'h0) | (32'(m_ce_n) << 16)
                    | (32'(m_ue_n) << 12) | (m_en_ue ? 32'h2 : 32'h0) | (m_en_ce ? 32'h1 : 32'h0);
      8'h58: return m_ue_a;
      8'h5C: return m_ce_a;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R4";
      8'h50: return "R5";
      8'h58: return "R7";
      8'h5C: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit m_irq;
      m_irq = (m_en_ce && m_ce_n != 0) || (m_en_ue && m_ue_n != 0);
      check("R10", {31'b0, irq}, {31'b0, m_irq});
      check(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic irq_is(bit exp, string tag);
    @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic pulse(bit ce, bit ue, logic [31:0] ca, logic [31:0] ua);
    @(negedge clk); #1;
    ce_evt = ce; ue_evt = ue; ce_evt_addr = ca; ue_evt_addr = ua;
    @(negedge clk); #1;
    ce_evt = 0; ue_evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(8'h00, 32'h0, "R1"); rd(8'h04, 32'h0, "R1"); rd(8'h50, 32'h0, "R1");
    rd(8'h58, 32'h0, "R1"); rd(8'h5C, 32'h0, "R1"); irq_is(0, "R1");
    // R3 writes dropped while locked
    wr(8'h04, 32'h90); rd(8'h04, 32'h0, "R3");
    wr(8'h50, 32'h3);  rd(8'h50, 32'h0, "R3");
    // R2 key handling
    wr(8'h00, 32'h1234_5678); rd(8'h00, 32'h0, "R2");
    wr(8'h00, KEY);           rd(8'h00, 32'h1, "R2");
    // R4 / R9
    wr(8'h04, 32'h10); rd(8'h04, 32'h10, "R4");
    pulse(1, 1, 32'h100, 32'h200);
    rd(8'h50, 32'h0, "R9"); rd(8'h5C, 32'h0, "R9");
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, 32'h90, "R4");
    // R10 enables, R5/R8 correctable
    wr(8'h50, 32'h3); rd(8'h50, 32'h3, "R10"); irq_is(0, "R10");
    pulse(1, 0, 32'h1000, 0); pulse(1, 0, 32'h2000, 0); pulse(1, 0, 32'h3000, 0);
    rd(8'h50, 32'h0003_0003, "R5"); rd(8'h5C, 32'h3000, "R8"); irq_is(1, "R10");
    // R6/R7 uncorrectable
    pulse(0, 1, 0, 32'hAAA0); pulse(0, 1, 0, 32'hBBB0);
    rd(8'h50, 32'h0003_2003, "R6"); rd(8'h58, 32'hAAA0, "R7");
    // R10 per-class enables
    wr(8'h50, 32'h0); irq_is(0, "R10"); rd(8'h50, 32'h0003_2000, "R10");
    wr(8'h50, 32'h2); irq_is(1, "R10");
    wr(8'h50, 32'h1); irq_is(1, "R10");
    wr(8'h50, 32'h3);
    // R6 / R5 saturation
    for (int i = 0; i < 20; i++) pulse(0, 1, 0, 32'hE000 + 32'(i));
    rd(8'h50, 32'h0003_F003, "R6"); rd(8'h58, 32'hAAA0, "R7");
    for (int i = 0; i < 260; i++) pulse(1, 0, 32'(i) * 16, 0);
    rd(8'h50, 32'h00FF_F003, "R5"); rd(8'h5C, 32'h1030, "R8");
    // R11 clear
    wr(8'h50, 32'h8000_0003); rd(8'h50, 32'h8000_0003, "R11"); irq_is(0, "R11");
    pulse(1, 1, 32'h4444, 32'h5555);
    rd(8'h50, 32'h8000_0003, "R11"); rd(8'h5C, 32'h1030, "R11"); rd(8'h58, 32'hAAA0, "R11");
    wr(8'h50, 32'h3);
    pulse(0, 1, 0, 32'hCCC0);
    rd(8'h58, 32'hCCC0, "R11"); rd(8'h50, 32'h0000_1003, "R11");
    // R12 read-only and unmapped
    wr(8'h58, 32'h5555); rd(8'h58, 32'hCCC0, "R12");
    wr(8'h5C, 32'h6666); rd(8'h5C, 32'h1030, "R12");
    wr(8'h50, 32'h00FF_F003); rd(8'h50, 32'h0000_1003, "R12");
    rd(8'h20, 32'h0, "R12");
    // simultaneous events
    pulse(1, 1, 32'h7770, 32'h8880);
    rd(8'h50, 32'h0001_2003, "R5"); rd(8'h5C, 32'h7770, "R8"); rd(8'h58, 32'hCCC0, "R7");
    // R2 relock, R3 locked behaviour
    wr(8'h00, ~KEY); rd(8'h00, 32'h0, "R2");
    wr(8'h04, 32'h0); rd(8'h04, 32'h90, "R3");
    pulse(1, 0, 32'h9990, 0);
    rd(8'h50, 32'h0002_2003, "R3"); rd(8'h5C, 32'h9990, "R3");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule